// File: doc/BRIEF.md
# Serial Receiver with Flow-Controlled Ring Buffer

This block turns an asynchronous serial line into a stream of bytes held in an on-chip circular store. A consumer pulls the bytes out one at a time over a valid/ready port. The port also reports how many bytes are waiting. The serial line runs at one start bit, eight data bits, no parity and one stop bit. The default divider gives 9600 baud from a 100 MHz clock with sixteen samples per bit.

The block asks the far end to pause by driving its request-to-send output low once more than half of the store is occupied. It drives the output high again once the occupancy is back at half or below. A sender that honours this signal never loses a byte.

A sender that ignores the signal keeps writing. The write position then runs around the ring and replaces the oldest unread bytes. When the consumer catches up, it finds one contiguous run of data missing.

Top module: `uart_rx_ring`

## Requirements
- R1: While reset is held and just after it is released, `fill_o` is 0, `rd_valid_o` is 0, `rts_o` is 1 and `frame_err_o` is 0.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 16*OVS_DIV clock cycles. Each good frame adds exactly one byte, equal to the data bits, and bytes leave in the order they arrived.
- R3: A low level on the line that has gone high again before the middle of the start bit is rejected. It adds no byte and raises no framing error.
- R4: If the stop bit samples low, the byte is discarded and `fill_o` is unchanged. `frame_err_o` is high for exactly one cycle, and the next good frame is received normally.
- R5: In the cycle after `fill_o` is above DEPTH/2 (128 by default), `rts_o` is 0.
- R6: In the cycle after `fill_o` is at or below DEPTH/2, `rts_o` is 1.
- R7: `fill_o` equals the number of stored bytes. `rd_valid_o` is 1 exactly when `fill_o` is nonzero. `rd_data_o` shows the oldest byte. A cycle with `rd_valid_o` and `rd_ready_i` both high removes that byte.
- R8: When 256 bytes are stored, a newly received byte replaces the oldest one and `fill_o` stays at 256. Readout then starts at the oldest surviving byte.
- R9: `fill_o` never exceeds DEPTH and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| rd_ready_i | input | 1 | Consumer accepts the byte on `rd_data_o` |
| rd_valid_o | output | 1 | At least one byte is stored |
| rd_data_o | output | 8 | Oldest stored byte |
| fill_o | output | DEPTH_LOG2+1 | Number of stored bytes, 0 to DEPTH |
| rts_o | output | 1 | 1: sender may transmit; 0: sender should pause |
| frame_err_o | output | 1 | One-cycle pulse when a frame's stop bit is low |

## Verification
The assertions assume that reset is held for at least one clock before any checking starts. They also assume that `rd_ready_i` changes only between clock edges. The receive line may do anything, because the properties cover occupancy, flow control and error pulses, not line timing.

The stimulus keeps each frame's bit time equal to 16*OVS_DIV clocks. Framing errors and false starts are created with deliberate lengths: a stop bit cut to three quarters of a bit, and a low glitch of a quarter bit. Reads are issued only when no frame is in progress, so the expected queue order stays exact.

// File: rtl/uart_rb_pkg.sv
`timescale 1ns/1ps
package uart_rb_pkg;

    // Width of one received character.
    localparam int DATA_W = 8;
    // Samples taken per bit period.
    localparam int OVS = 16;
    localparam int OVS_W = $clog2(OVS);
    localparam int BITCNT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Result of one completed frame.
    typedef struct packed {
        logic              push;
        logic              bad;
        logic [DATA_W-1:0] data;
    } rx_evt_t;

    // Bits arrive least significant first: each new bit enters at the top.
    function automatic logic [DATA_W-1:0] shift_lsb_first(
        input logic [DATA_W-1:0] cur,
        input logic              b
    );
        return {b, cur[DATA_W-1:1]};
    endfunction

endpackage

// File: rtl/uart_rb_tick.sv
`timescale 1ns/1ps
module uart_rb_tick #(
    parameter int DIV = 651
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divider: one pulse every DIV clocks.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/uart_rb_deser.sv
`timescale 1ns/1ps
module uart_rb_deser
    import uart_rb_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    tick_i,
    input  logic    rx_i,
    output rx_evt_t evt_o
);
    localparam logic [OVS_W-1:0]    HALF_SMP = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0]    FULL_SMP = OVS_W'(OVS - 1);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(DATA_W - 1);

    logic              rx_meta_q, rx_sync_q;
    rx_state_e         state_q;
    logic [OVS_W-1:0]  smp_q;
    logic [BITCNT_W-1:0] bit_q;
    logic [DATA_W-1:0] shift_q;
    rx_evt_t           evt_q;

    // Two-stage synchroniser for the asynchronous line; idles high.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rx_meta_q <= 1'b1;
            rx_sync_q <= 1'b1;
        end else begin
            rx_meta_q <= rx_i;
            rx_sync_q <= rx_meta_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RX_IDLE;
            smp_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            evt_q   <= '0;
        end else begin
            evt_q.push <= 1'b0;
            evt_q.bad  <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    smp_q <= '0;
                    if (!rx_sync_q) state_q <= RX_START;
                end
                RX_START: begin
                    if (tick_i) begin
                        if (smp_q == HALF_SMP) begin
                            // Middle of start bit: confirm or reject.
                            smp_q <= '0;
                            bit_q <= '0;
                            state_q <= rx_sync_q ? RX_IDLE : RX_DATA;
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick_i) begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == FULL_SMP) begin
                            shift_q <= shift_lsb_first(shift_q, rx_sync_q);
                            bit_q   <= bit_q + 1'b1;
                            if (bit_q == LAST_BIT) state_q <= RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) begin
                        smp_q <= smp_q + 1'b1;
                        if (smp_q == FULL_SMP) begin
                            state_q    <= RX_IDLE;
                            evt_q.data <= shift_q;
                            evt_q.push <= rx_sync_q;
                            evt_q.bad  <= !rx_sync_q;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/uart_rb_ring.sv
`timescale 1ns/1ps
module uart_rb_ring
    import uart_rb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  push_i,
    input  logic [DATA_W-1:0]     push_data_i,
    input  logic                  pop_ready_i,
    output logic                  pop_valid_o,
    output logic [DATA_W-1:0]     pop_data_o,
    output logic [DEPTH_LOG2:0]   fill_o,
    output logic                  rts_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] DEPTH_V = (DEPTH_LOG2+1)'(DEPTH);
    localparam logic [DEPTH_LOG2:0] HALF_V  = (DEPTH_LOG2+1)'(DEPTH / 2);

    logic [DATA_W-1:0]     mem_q [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_q, rd_q;
    logic                  full_q;
    logic                  rts_q;
    logic                  pop, rd_adv;
    logic [DEPTH_LOG2:0]   fill;

    assign fill        = full_q ? DEPTH_V : {1'b0, wr_q - rd_q};
    assign pop_valid_o = full_q || (wr_q != rd_q);
    assign pop         = pop_valid_o && pop_ready_i;
    // A write into a full ring pushes the oldest entry out.
    assign rd_adv      = pop || (push_i && full_q);

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[wr_q] <= push_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_q   <= '0;
            rd_q   <= '0;
            full_q <= 1'b0;
        end else begin
            if (push_i) wr_q <= wr_q + 1'b1;
            if (rd_adv) rd_q <= rd_q + 1'b1;
            if (push_i && !pop) begin
                full_q <= full_q || ((wr_q + 1'b1) == rd_q);
            end else if (pop && !push_i) begin
                full_q <= 1'b0;
            end
        end
    end

    // Flow control follows occupancy one cycle later.
    always_ff @(posedge clk_i) begin
        if (rst_i) rts_q <= 1'b1;
        else       rts_q <= (fill <= HALF_V);
    end

    assign pop_data_o = mem_q[rd_q];
    assign fill_o     = fill;
    assign rts_o      = rts_q;
endmodule

// File: rtl/uart_rx_ring.sv
`timescale 1ns/1ps
module uart_rx_ring
    import uart_rb_pkg::*;
#(
    parameter int OVS_DIV    = 651,
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  rx_i,
    input  logic                  rd_ready_i,
    output logic                  rd_valid_o,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [DEPTH_LOG2:0]   fill_o,
    output logic                  rts_o,
    output logic                  frame_err_o
);
    logic    tick;
    rx_evt_t evt;

    uart_rb_tick #(.DIV(OVS_DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    uart_rb_deser deser_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .rx_i   (rx_i),
        .evt_o  (evt)
    );

    uart_rb_ring #(.DEPTH_LOG2(DEPTH_LOG2)) ring_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .push_i      (evt.push),
        .push_data_i (evt.data),
        .pop_ready_i (rd_ready_i),
        .pop_valid_o (rd_valid_o),
        .pop_data_o  (rd_data_o),
        .fill_o      (fill_o),
        .rts_o       (rts_o)
    );

    assign frame_err_o = evt.bad;
endmodule

// File: rtl/uart_rx_ring_chk.sv
`timescale 1ns/1ps
module uart_rx_ring_chk #(
    parameter int DEPTH_LOG2 = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                rd_valid_o,
    input logic [DEPTH_LOG2:0] fill_o,
    input logic                rts_o,
    input logic                frame_err_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] HALF_V  = (DEPTH_LOG2+1)'(DEPTH / 2);
    localparam logic [DEPTH_LOG2:0] DEPTH_V = (DEPTH_LOG2+1)'(DEPTH);

    assert_rts_pause_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_o > HALF_V) |=> !rts_o);

    assert_rts_resume_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_o <= HALF_V) |=> rts_o);

    assert_valid_tracks_fill_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o == (fill_o != '0));

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        fill_o <= DEPTH_V);

    assert_fill_step_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + 1'b1)
        || (fill_o + 1'b1 == $past(fill_o)));

    assert_bad_frame_no_push_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_err_o |=> (fill_o <= $past(fill_o)));

    assert_err_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_err_o |=> !frame_err_o);
endmodule

bind uart_rx_ring uart_rx_ring_chk #(.DEPTH_LOG2(DEPTH_LOG2)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .rd_valid_o  (rd_valid_o),
    .fill_o      (fill_o),
    .rts_o       (rts_o),
    .frame_err_o (frame_err_o)
);

// File: tb/uart_rx_ring_tb_top.sv
`timescale 1ns/1ps
module uart_rx_ring_tb_top;
    localparam int OVS_DIV    = 2;
    localparam int DEPTH_LOG2 = 8;
    localparam int DEPTH      = 256;
    localparam int HALF       = 128;
    localparam int BIT_NS     = 16 * OVS_DIV * 10;

    // Vector table: {byte sent, expected fill afterwards}.
    localparam logic [15:0] VEC [8] = '{
        {8'h55, 8'd1}, {8'hA3, 8'd2}, {8'h00, 8'd3}, {8'hFF, 8'd4},
        {8'h01, 8'd5}, {8'h80, 8'd6}, {8'h3C, 8'd7}, {8'hC5, 8'd8}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [8:0] fill;
    logic       rts;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int ferr_seen = 0;
    logic [7:0] model[$];

    uart_rx_ring #(.OVS_DIV(OVS_DIV), .DEPTH_LOG2(DEPTH_LOG2)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .rx_i        (rx),
        .rd_ready_i  (rd_ready),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .fill_o      (fill),
        .rts_o       (rts),
        .frame_err_o (frame_err)
    );

    always @(posedge clk) if (!rst && frame_err) ferr_seen++;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit good_stop);
        rx = 1'b0;
        #(BIT_NS);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            #(BIT_NS);
        end
        if (good_stop) begin
            rx = 1'b1;
            #(BIT_NS);
        end else begin
            rx = 1'b0;
            #(BIT_NS * 3 / 4);
            rx = 1'b1;
            #(BIT_NS / 4);
        end
        #(BIT_NS);
    endtask

    // Sends a good frame and updates the expected ring, dropping the oldest when full.
    task automatic send_good(input logic [7:0] b);
        if (model.size() == DEPTH) void'(model.pop_front());
        model.push_back(b);
        send(b, 1'b1);
    endtask

    task automatic pop_check(input string req);
        logic [7:0] exp;
        @(negedge clk);
        exp = model.pop_front();
        check_eq({req, " valid"}, int'(rd_valid), 1);
        check_eq({req, " data"}, int'(rd_data), int'(exp));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: state under reset and just after release
        check_eq("R1 fill in reset", int'(fill), 0);
        check_eq("R1 rts in reset", int'(rts), 1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 fill", int'(fill), 0);
        check_eq("R1 valid", int'(rd_valid), 0);
        check_eq("R1 rts", int'(rts), 1);
        check_eq("R1 frame_err", int'(frame_err), 0);

        // R2 / R7: table of frames, occupancy after each
        for (int v = 0; v < 8; v++) begin
            send_good(VEC[v][15:8]);
            @(negedge clk);
            check_eq("R2 fill after frame", int'(fill), int'(VEC[v][7:0]));
        end
        for (int v = 0; v < 8; v++) pop_check("R2 order");
        @(negedge clk);
        check_eq("R7 fill drained", int'(fill), 0);
        check_eq("R7 valid drained", int'(rd_valid), 0);

        // R3: short low glitch is not a start bit
        rx = 1'b0;
        #(BIT_NS / 4);
        rx = 1'b1;
        #(BIT_NS * 2);
        @(negedge clk);
        check_eq("R3 glitch fill", int'(fill), 0);
        check_eq("R3 glitch ferr", ferr_seen, 0);

        // R4: low stop bit discards the byte, then a good frame is accepted
        send(8'h5A, 1'b0);
        @(negedge clk);
        check_eq("R4 bad frame fill", int'(fill), 0);
        check_eq("R4 frame_err pulses", ferr_seen, 1);
        send_good(8'h96);
        @(negedge clk);
        check_eq("R4 recovery fill", int'(fill), 1);
        pop_check("R4 recovery");

        // R5 / R6: threshold at half occupancy
        for (int i = 0; i < HALF; i++) send_good(8'((i * 37 + 11)));
        @(negedge clk);
        check_eq("R6 fill at half", int'(fill), HALF);
        check_eq("R6 rts at half", int'(rts), 1);
        send_good(8'hE7);
        @(negedge clk);
        check_eq("R5 fill above half", int'(fill), HALF + 1);
        check_eq("R5 rts above half", int'(rts), 0);
        pop_check("R7 pop oldest");
        check_eq("R7 fill after pop", int'(fill), HALF);
        @(negedge clk);
        check_eq("R6 rts after pop", int'(rts), 1);

        // R8: sender ignores rts, ring wraps over oldest data
        for (int i = 0; i < 130; i++) send_good(8'((i * 53 + 7)));
        @(negedge clk);
        check_eq("R8 fill saturates", int'(fill), DEPTH);
        check_eq("R5 rts while full", int'(rts), 0);
        for (int i = 0; i < DEPTH; i++) pop_check("R8 surviving order");
        @(negedge clk);
        check_eq("R8 fill empty", int'(fill), 0);
        check_eq("R7 valid empty", int'(rd_valid), 0);
        check_eq("R6 rts empty", int'(rts), 1);
        check_eq("R4 no extra frame errors", ferr_seen, 1);

        finish_run();
    end
endmodule